// File: doc/BRIEF.md
# Three-Phase Leg Crossover Guard

This block sits between the filtered gate commands of a three-phase inverter controller and the gate driver stages. Each of its three identical phase channels receives an active-low high-side command and an active-low low-side command, translates them into active-high gate requests for the upper and lower switch of one leg, and makes sure that the two switches of the leg never conduct together.

On every handover from one switch of a leg to the other, the channel keeps both gates low for at least a fixed number of clock cycles. Any part of that gap that the commands already provide counts toward it, so a gap that is long enough passes through with no extra delay. A global enable from the protection supervisor removes both gates of every phase at once. The high side of each phase also has its own qualifiers. A per-phase floating-supply-good flag must be present, and after that flag has been lost the high side re-arms only on a fresh falling edge of its command. A negative switch-node transient flag holds that high side low for a fixed interval.

The deadtime and the transient hold interval are parameters in clock cycles. All three phases share the same values, so handovers in either direction and on every phase get the same deadtime.

Top module: `leg_guard_top`

## Requirements
- R1: Per phase, command pair (hs_cmd_ni, ls_cmd_ni) = (0,1) requests the high gate only, (1,0) requests the low gate only, and (0,0) or (1,1) requests neither gate.
- R2: Every gate output is registered once, so turn-on and turn-off both appear one clock after the commands are sampled, and an output pulse is as wide as its command pulse apart from inserted deadtime.
- R3: hs_gate_o[p] and ls_gate_o[p] are never high in the same cycle.
- R4: A gate that turns on after the opposite gate of its leg was on does so only after both gates of that leg have been low for DT_CYC cycles. When the commands give a shorter gap, the output gap is exactly DT_CYC cycles.
- R5: A commanded gap of DT_CYC cycles or more passes through without added delay. A gate turning back on after itself was the last one on needs no deadtime.
- R6: en_i low forces both gates of every phase low one clock later. After en_i returns high, a gate turns on only once both gates have been low for DT_CYC cycles with en_i high.
- R7: hs_en_i[p] low forces hs_gate_o[p] low one clock later and disarms the high side. Once hs_en_i[p] is high again, the high side stays off until hs_cmd_ni[p] falls while hs_en_i[p] is high.
- R8: neg_tr_i[p] sampled high forces hs_gate_o[p] low one clock later and keeps it low for NEG_HOLD_CYC cycles after the last cycle it was sampled high. ls_gate_o[p] is not affected.
- R9: While rst_ni is low, all gates are low. After reset the high sides are armed, and the first turn-on needs no deadtime.
- R10: The phases are independent. A handover on one phase leaves the gates of the other phases unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global enable from the protection supervisor; low removes all gates |
| hs_cmd_ni | input | NUM_PH | Active-low high-side commands, one per phase |
| ls_cmd_ni | input | NUM_PH | Active-low low-side commands, one per phase |
| hs_en_i | input | NUM_PH | Floating-supply-good flags, one per phase |
| neg_tr_i | input | NUM_PH | Negative switch-node transient flags, one per phase |
| hs_gate_o | output | NUM_PH | Active-high high-side gate requests |
| ls_gate_o | output | NUM_PH | Active-high low-side gate requests |

## Verification
The two functions that can fall in the same cycle are deadtime expiry and global disable. The bench drives a low-to-high handover and lowers en_i on exactly the clock edge at which the deadtime would have been complete. It then checks that the gates stay low through that edge, and that the full deadtime is counted again from the moment en_i returns rather than resuming the old count. A second overlap comes from the end of a transient hold meeting a pending handover: the high side must wait for whichever of the two releases comes later.

// File: rtl/leg_guard_pkg.sv
package leg_guard_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HS   = 2'd1,
    SIDE_LS   = 2'd2
  } side_e;

  typedef struct packed {
    logic hs;
    logic ls;
  } gate_req_t;

endpackage

// File: rtl/leg_cmd_decode.sv
module leg_cmd_decode
  import leg_guard_pkg::*;
(
  input  logic      hs_cmd_ni,
  input  logic      ls_cmd_ni,
  output gate_req_t req_o
);

  // inverting inputs: exactly one low selects that switch
  always_comb begin
    req_o.hs = ~hs_cmd_ni &  ls_cmd_ni;
    req_o.ls =  hs_cmd_ni & ~ls_cmd_ni;
  end

endmodule

// File: rtl/leg_hs_qualify.sv
module leg_hs_qualify #(
  parameter int unsigned HOLD_CYC = 225
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_cmd_ni,
  input  logic hs_en_i,
  input  logic neg_tr_i,
  output logic hs_ok_o
);

  localparam int unsigned HOLD_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC - 1);

  logic              cmd_q;
  logic              arm_q;
  logic              fall;
  logic              arm_now;
  logic [HOLD_W-1:0] hold_q;

  assign fall    = cmd_q & ~hs_cmd_ni;
  // re-arm only on a fresh command edge seen while the supply is good
  assign arm_now = hs_en_i & (arm_q | fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= 1'b1;
      arm_q  <= 1'b1;
      hold_q <= '0;
    end else begin
      cmd_q <= hs_cmd_ni;
      arm_q <= arm_now;
      if (neg_tr_i) begin
        hold_q <= HOLD_LOAD;
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign hs_ok_o = arm_now & ~neg_tr_i & (hold_q == '0);

endmodule

// File: rtl/leg_dt_gate.sv
module leg_dt_gate
  import leg_guard_pkg::*;
#(
  parameter int unsigned DT_CYC = 35
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  gate_req_t req_i,
  output gate_req_t gate_o
);

  localparam int unsigned CNT_W = $clog2(DT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DT_CYC);

  gate_req_t        gate_q, gate_d;
  side_e            last_q, last_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gap_done;
  logic             hs_allow;
  logic             ls_allow;

  // cnt_q: cycles both gates have been low, saturating at DT_CYC
  assign gap_done = (cnt_q >= CNT_MAX);
  assign hs_allow = gate_q.hs | (~gate_q.ls & ((last_q == SIDE_HS) | gap_done));
  assign ls_allow = gate_q.ls | (~gate_q.hs & ((last_q == SIDE_LS) | gap_done));

  always_comb begin
    gate_d.hs = en_i & req_i.hs & hs_allow;
    gate_d.ls = en_i & req_i.ls & ls_allow;

    if (!en_i) begin
      last_d = SIDE_NONE;
    end else if (gate_d.hs) begin
      last_d = SIDE_HS;
    end else if (gate_d.ls) begin
      last_d = SIDE_LS;
    end else begin
      last_d = last_q;
    end

    if (!en_i || gate_d.hs || gate_d.ls) begin
      cnt_d = '0;
    end else if (gap_done) begin
      cnt_d = CNT_MAX;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      last_q <= SIDE_NONE;
      cnt_q  <= CNT_MAX;
    end else begin
      gate_q <= gate_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/leg_phase.sv
module leg_phase
  import leg_guard_pkg::*;
#(
  parameter int unsigned DT_CYC   = 35,
  parameter int unsigned HOLD_CYC = 225
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hs_cmd_ni,
  input  logic ls_cmd_ni,
  input  logic hs_en_i,
  input  logic neg_tr_i,
  output logic hs_gate_o,
  output logic ls_gate_o
);

  gate_req_t raw_req;
  gate_req_t qual_req;
  gate_req_t gate;
  logic      hs_ok;

  leg_cmd_decode u_dec (
    .hs_cmd_ni (hs_cmd_ni),
    .ls_cmd_ni (ls_cmd_ni),
    .req_o     (raw_req)
  );

  leg_hs_qualify #(
    .HOLD_CYC (HOLD_CYC)
  ) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_cmd_ni (hs_cmd_ni),
    .hs_en_i   (hs_en_i),
    .neg_tr_i  (neg_tr_i),
    .hs_ok_o   (hs_ok)
  );

  always_comb begin
    qual_req.hs = raw_req.hs & hs_ok;
    qual_req.ls = raw_req.ls;
  end

  leg_dt_gate #(
    .DT_CYC (DT_CYC)
  ) u_dt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .req_i  (qual_req),
    .gate_o (gate)
  );

  assign hs_gate_o = gate.hs;
  assign ls_gate_o = gate.ls;

endmodule

// File: rtl/leg_guard_top.sv
module leg_guard_top #(
  parameter int unsigned NUM_PH       = 3,
  parameter int unsigned DT_CYC       = 35,
  parameter int unsigned NEG_HOLD_CYC = 225
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NUM_PH-1:0] hs_cmd_ni,
  input  logic [NUM_PH-1:0] ls_cmd_ni,
  input  logic [NUM_PH-1:0] hs_en_i,
  input  logic [NUM_PH-1:0] neg_tr_i,
  output logic [NUM_PH-1:0] hs_gate_o,
  output logic [NUM_PH-1:0] ls_gate_o
);

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    leg_phase #(
      .DT_CYC   (DT_CYC),
      .HOLD_CYC (NEG_HOLD_CYC)
    ) u_ph (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .hs_cmd_ni (hs_cmd_ni[p]),
      .ls_cmd_ni (ls_cmd_ni[p]),
      .hs_en_i   (hs_en_i[p]),
      .neg_tr_i  (neg_tr_i[p]),
      .hs_gate_o (hs_gate_o[p]),
      .ls_gate_o (ls_gate_o[p])
    );
  end

endmodule

// File: rtl/leg_guard_chk.sv
module leg_guard_chk
  import leg_guard_pkg::*;
#(
  parameter int unsigned NUM_PH = 3,
  parameter int unsigned DT_CYC = 35
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [NUM_PH-1:0] hs_cmd_ni,
  input logic [NUM_PH-1:0] ls_cmd_ni,
  input logic [NUM_PH-1:0] hs_en_i,
  input logic [NUM_PH-1:0] neg_tr_i,
  input logic [NUM_PH-1:0] hs_gate_o,
  input logic [NUM_PH-1:0] ls_gate_o
);

  localparam int unsigned GAP_W = $clog2(DT_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DT_CYC);

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    logic [GAP_W-1:0] gap_q;
    side_e            side_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gap_q  <= GAP_MAX;
        side_q <= SIDE_NONE;
      end else if (hs_gate_o[p] | ls_gate_o[p]) begin
        gap_q  <= '0;
        side_q <= hs_gate_o[p] ? SIDE_HS : SIDE_LS;
      end else if (gap_q != GAP_MAX) begin
        gap_q <= gap_q + 1'b1;
      end
    end

    // R1
    decode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hs_cmd_ni[p] == ls_cmd_ni[p]) |=> (!hs_gate_o[p] && !ls_gate_o[p]));

    // R3
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_gate_o[p] && ls_gate_o[p]));

    // R4
    dt_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(hs_gate_o[p]) && side_q == SIDE_LS) |-> (gap_q >= GAP_MAX));

    // R4
    dt_ls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ls_gate_o[p]) && side_q == SIDE_HS) |-> (gap_q >= GAP_MAX));

    // R6
    disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!hs_gate_o[p] && !ls_gate_o[p]));

    // R7
    uv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hs_en_i[p] |=> !hs_gate_o[p]);

    // R8
    neg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      neg_tr_i[p] |=> !hs_gate_o[p]);
  end

endmodule

bind leg_guard_top leg_guard_chk #(
  .NUM_PH (NUM_PH),
  .DT_CYC (DT_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .hs_cmd_ni (hs_cmd_ni),
  .ls_cmd_ni (ls_cmd_ni),
  .hs_en_i   (hs_en_i),
  .neg_tr_i  (neg_tr_i),
  .hs_gate_o (hs_gate_o),
  .ls_gate_o (ls_gate_o)
);

// File: tb/sim_leg_guard_top.sv
module sim_leg_guard_top;

  localparam int unsigned NUM_PH = 3;
  localparam int unsigned DT     = 3;
  localparam int unsigned HOLD   = 4;
  localparam int          NVEC   = 37;

  // row: {en, hs_en, neg, hs_cmd_n, ls_cmd_n, exp_hs, exp_ls}, applied to all phases
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1_1_0_1_1_0_0, 7'b1_1_0_0_1_1_0, 7'b1_1_0_0_1_1_0, 7'b1_1_0_1_0_0_0,
    7'b1_1_0_1_0_0_0, 7'b1_1_0_1_0_0_0, 7'b1_1_0_1_0_0_1, 7'b1_1_0_0_0_0_0,
    7'b1_1_0_0_1_0_0, 7'b1_1_0_0_1_0_0, 7'b1_1_0_0_1_1_0, 7'b1_1_0_1_1_0_0,
    7'b1_1_0_1_1_0_0, 7'b1_1_0_1_1_0_0, 7'b1_1_0_1_0_0_1, 7'b1_1_0_1_1_0_0,
    7'b1_1_0_1_0_0_1, 7'b0_1_0_1_0_0_0, 7'b1_1_0_1_0_0_0, 7'b1_1_0_1_0_0_0,
    7'b1_1_0_1_0_0_0, 7'b1_1_0_1_0_0_1, 7'b1_1_0_0_1_0_0, 7'b1_0_0_0_1_0_0,
    7'b1_1_0_0_1_0_0, 7'b1_1_0_0_1_0_0, 7'b1_1_0_1_1_0_0, 7'b1_1_0_0_1_1_0,
    7'b1_1_1_0_1_0_0, 7'b1_1_0_0_1_0_0, 7'b1_1_0_0_1_0_0, 7'b1_1_0_0_1_0_0,
    7'b1_1_0_0_1_1_0, 7'b1_1_0_1_1_0_0, 7'b1_1_1_1_1_0_0, 7'b1_1_1_1_1_0_0,
    7'b1_1_0_1_0_0_1
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en;
  logic [NUM_PH-1:0] hs_cmd_n, ls_cmd_n, hs_en, neg_tr;
  logic [NUM_PH-1:0] hs_gate, ls_gate;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  leg_guard_top #(
    .NUM_PH       (NUM_PH),
    .DT_CYC       (DT),
    .NEG_HOLD_CYC (HOLD)
  ) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .hs_cmd_ni (hs_cmd_n),
    .ls_cmd_ni (ls_cmd_n),
    .hs_en_i   (hs_en),
    .neg_tr_i  (neg_tr),
    .hs_gate_o (hs_gate),
    .ls_gate_o (ls_gate)
  );

  function automatic string row_req(int i);
    if (i == 1) return "R9";
    if (i == 0 || i == 2 || i == 7) return "R1";
    if (i <= 10) return "R4";
    if (i <= 13) return "R2";
    if (i <= 16) return "R5";
    if (i <= 21) return "R6";
    if (i <= 27) return "R7";
    return "R8";
  endfunction

  task automatic chk(string req, logic [NUM_PH-1:0] exp_h, logic [NUM_PH-1:0] exp_l);
    n_chk++;
    if (hs_gate !== exp_h || ls_gate !== exp_l) begin
      n_fail++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b at %0t",
               req, hs_gate, ls_gate, exp_h, exp_l, $time);
    end
  endtask

  task automatic chk_excl(string req);
    n_chk++;
    if ((hs_gate & ls_gate) != '0) begin
      n_fail++;
      $display("FAIL %s: overlap hs&ls=%b expected 000", req, hs_gate & ls_gate);
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, actual cycles=4000 expected fewer");
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    en       = 1'b1;
    hs_en    = '1;
    neg_tr   = '0;
    hs_cmd_n = '0;
    ls_cmd_n = '1;
    repeat (3) @(negedge clk);
    // R9: held in reset with high side requested
    chk("R9", '0, '0);
    hs_cmd_n = '1;
    rst_ni   = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      en       = VEC[i][6];
      hs_en    = {NUM_PH{VEC[i][5]}};
      neg_tr   = {NUM_PH{VEC[i][4]}};
      hs_cmd_n = {NUM_PH{VEC[i][3]}};
      ls_cmd_n = {NUM_PH{VEC[i][2]}};
      @(negedge clk);
      chk(row_req(i), {NUM_PH{VEC[i][1]}}, {NUM_PH{VEC[i][0]}});
      chk_excl("R3");
    end

    // R6: disable lands on the edge where low-to-high deadtime would expire
    en = 1'b1; hs_cmd_n = '0; ls_cmd_n = '1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4", '0, '0);
    end
    en = 1'b0;
    @(negedge clk);
    chk("R6", '0, '0);
    en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6", '0, '0);
    end
    @(negedge clk);
    chk("R6", '1, '0);

    // R10: handover on phase 1 only
    hs_cmd_n = 3'b010; ls_cmd_n = 3'b101;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", 3'b101, 3'b000);
    end
    @(negedge clk);
    chk("R10", 3'b101, 3'b010);
    chk_excl("R3");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule